// File: doc/BRIEF.md
# Overpower Dwell Timer with Automatic Retry

This block guards a pass switch against sustained overpower. Each clock it compares a digitized estimate of the power dissipated in the switch with a fixed limit. That estimate is an unsigned value in milliwatts, formed elsewhere from the voltage across the switch and the current through it. The estimate is compared in every operating condition, current limiting included, because a limited current with a large voltage drop can still dissipate a lot. Elapsed time is measured in ticks from a timebase strobe. Overpower that stays continuously for more than the dwell window opens the switch.

Once the switch is tripped, it stays open for a fixed cool-off time and then closes again without any outside action. If the overload is still there, the dwell window runs again from zero and the trip-and-retry cycle repeats. The trip flag goes to the fault logic. Dropping the enable request stops everything at once and clears both timers.

Top module: `opt_guard`

## Requirements
- R1: While reset is asserted and after its release with no enable request, `sw_en_o` and `soa_trip_o` are both 0.
- R2: With the block idle, an enable request sets `sw_en_o` to 1 at the next clock edge, with `soa_trip_o` at 0.
- R3: Overpower means `pwr_mw_i >= TRIP_MW` (default 5000 mW). A value one below the limit never trips the switch, however long it lasts.
- R4: The switch opens only on the tick that would take the count of consecutive overpower ticks past `DWELL_TICKS` (default 250, that is 2.5 ms of 10 µs ticks). After exactly `DWELL_TICKS` ticks the switch is still closed, and it opens at the next tick that still sees overpower.
- R5: Any clock cycle with the power below the limit resets the dwell count to zero. After that, a fresh full window is needed before a trip.
- R6: Time advances only on cycles with `tick_i` high. Overpower on cycles without a tick never trips the switch.
- R7: On a trip, `sw_en_o` goes to 0 and `soa_trip_o` goes to 1. Both stay that way for exactly `COOL_TICKS` ticks (default 16000, that is 160 ms). On the last of those ticks the switch closes and the flag clears. The power input has no effect during cool-off.
- R8: After a retry, operation continues if the power is below the limit. If overpower persists, the dwell count starts from zero and the block trips again after another full window.
- R9: Dropping `en_i` sends the block to idle at the next edge from any state (both outputs 0) and clears both counters. A later enable therefore starts a fresh dwell window.
- R10: `sw_en_o` and `soa_trip_o` are never both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Enable request for the switch |
| tick_i | input | 1 | Timebase strobe, one cycle per time unit |
| pwr_mw_i | input | PWR_W | Dissipated power estimate, unsigned, in mW |
| sw_en_o | output | 1 | Switch enable |
| soa_trip_o | output | 1 | Overpower trip flag, high during cool-off |

## Verification
The bench places the power exactly one milliwatt below the limit and exactly at it. An off-by-one comparator would then trip on 4999 mW or ignore 5000 mW. It runs overpower for exactly the dwell count and then one tick more, which exposes a trip one tick early or late. It inserts a single below-limit cycle inside an excursion, so a design that only pauses the dwell count would trip early. It also holds overpower with the tick low, so a design that counts clocks instead of ticks would trip. In cool-off, the bench checks every tick of the interval and then holds overpower across a retry. A design that kept the old dwell count would re-trip at once, and one that latched off would never close the switch. Finally, it drops the enable in the middle of cool-off and re-enables, which shows whether stale counts survive.

// File: rtl/opt_pkg.sv
package opt_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_COOL = 2'd2
  } opt_state_e;
endpackage

// File: rtl/opt_over_cmp.sv
module opt_over_cmp #(
  parameter int PWR_W   = 16,
  parameter int TRIP_MW = 5000
) (
  input  logic [PWR_W-1:0] pwr_i,
  output logic             over_o
);
  localparam logic [PWR_W-1:0] LIMIT = PWR_W'(TRIP_MW);
  assign over_o = (pwr_i >= LIMIT);
endmodule

// File: rtl/opt_tick_cnt.sv
module opt_tick_cnt #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         inc_i,
  output logic [W-1:0] cnt_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cnt_o <= '0;
    else if (clr_i) cnt_o <= '0;
    else if (inc_i) cnt_o <= cnt_o + 1'b1;
  end
endmodule

// File: rtl/opt_ctrl.sv
module opt_ctrl
  import opt_pkg::*;
#(
  parameter int DWELL_TICKS = 250,
  parameter int COOL_TICKS  = 16000,
  parameter int DW          = 8,
  parameter int CW          = 14
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          en_i,
  input  logic          tick_i,
  input  logic          over_i,
  input  logic [DW-1:0] dwell_cnt_i,
  input  logic [CW-1:0] cool_cnt_i,
  output opt_state_e    state_o,
  output logic          dwell_clr_o,
  output logic          dwell_inc_o,
  output logic          cool_clr_o,
  output logic          cool_inc_o
);
  localparam logic [DW-1:0] DWELL_LAST = DW'(DWELL_TICKS);
  localparam logic [CW-1:0] COOL_LAST  = CW'(COOL_TICKS - 1);

  opt_state_e state_q, state_d;
  logic dwell_last, cool_last;

  assign dwell_last = (dwell_cnt_i == DWELL_LAST);
  assign cool_last  = (cool_cnt_i == COOL_LAST);

  always_comb begin
    state_d     = state_q;
    dwell_clr_o = 1'b1;
    dwell_inc_o = 1'b0;
    cool_clr_o  = 1'b1;
    cool_inc_o  = 1'b0;
    unique case (state_q)
      ST_IDLE: if (en_i) state_d = ST_RUN;
      ST_RUN: begin
        if (!en_i) begin
          state_d = ST_IDLE;
        end else if (over_i) begin
          dwell_clr_o = 1'b0;
          if (tick_i) begin
            if (dwell_last) begin
              state_d     = ST_COOL;
              dwell_clr_o = 1'b1;
            end else begin
              dwell_inc_o = 1'b1;
            end
          end
        end
      end
      ST_COOL: begin
        if (!en_i) begin
          state_d = ST_IDLE;
        end else begin
          cool_clr_o = 1'b0;
          if (tick_i) begin
            if (cool_last) begin
              state_d    = ST_RUN;
              cool_clr_o = 1'b1;
            end else begin
              cool_inc_o = 1'b1;
            end
          end
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_IDLE;
    else         state_q <= state_d;
  end

  assign state_o = state_q;
endmodule

// File: rtl/opt_guard.sv
module opt_guard
  import opt_pkg::*;
#(
  parameter int PWR_W       = 16,
  parameter int TRIP_MW     = 5000,
  parameter int DWELL_TICKS = 250,
  parameter int COOL_TICKS  = 16000
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             tick_i,
  input  logic [PWR_W-1:0] pwr_mw_i,
  output logic             sw_en_o,
  output logic             soa_trip_o
);
  localparam int DW = $clog2(DWELL_TICKS + 1);
  localparam int CW = (COOL_TICKS > 1) ? $clog2(COOL_TICKS) : 1;

  logic          over;
  logic [DW-1:0] dwell_cnt;
  logic [CW-1:0] cool_cnt;
  logic          dwell_clr, dwell_inc, cool_clr, cool_inc;
  opt_state_e    state;

  opt_over_cmp #(.PWR_W(PWR_W), .TRIP_MW(TRIP_MW)) i_cmp (
    .pwr_i  (pwr_mw_i),
    .over_o (over)
  );

  opt_tick_cnt #(.W(DW)) i_dwell_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (dwell_clr),
    .inc_i  (dwell_inc),
    .cnt_o  (dwell_cnt)
  );

  opt_tick_cnt #(.W(CW)) i_cool_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (cool_clr),
    .inc_i  (cool_inc),
    .cnt_o  (cool_cnt)
  );

  opt_ctrl #(
    .DWELL_TICKS (DWELL_TICKS),
    .COOL_TICKS  (COOL_TICKS),
    .DW          (DW),
    .CW          (CW)
  ) i_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .en_i        (en_i),
    .tick_i      (tick_i),
    .over_i      (over),
    .dwell_cnt_i (dwell_cnt),
    .cool_cnt_i  (cool_cnt),
    .state_o     (state),
    .dwell_clr_o (dwell_clr),
    .dwell_inc_o (dwell_inc),
    .cool_clr_o  (cool_clr),
    .cool_inc_o  (cool_inc)
  );

  assign sw_en_o    = (state == ST_RUN);
  assign soa_trip_o = (state == ST_COOL);
endmodule

// File: rtl/opt_guard_chk.sv
module opt_guard_chk #(
  parameter int PWR_W   = 16,
  parameter int TRIP_MW = 5000
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             en_i,
  input logic             tick_i,
  input logic [PWR_W-1:0] pwr_mw_i,
  input logic             sw_en_o,
  input logic             soa_trip_o
);
  localparam logic [PWR_W-1:0] LIMIT = PWR_W'(TRIP_MW);

  p_exclusive_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(sw_en_o && soa_trip_o));

  p_drop_idle_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (!sw_en_o && !soa_trip_o));

  p_start_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !sw_en_o && !soa_trip_o) |=> sw_en_o);

  p_below_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && sw_en_o && pwr_mw_i < LIMIT) |=> sw_en_o);

  p_no_tick_run_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && sw_en_o && !tick_i) |=> sw_en_o);

  p_no_tick_cool_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && soa_trip_o && !tick_i) |=> soa_trip_o);

  p_trip_from_run_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(soa_trip_o) |-> $past(sw_en_o));
endmodule

bind opt_guard opt_guard_chk #(.PWR_W(PWR_W), .TRIP_MW(TRIP_MW)) i_opt_guard_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .en_i       (en_i),
  .tick_i     (tick_i),
  .pwr_mw_i   (pwr_mw_i),
  .sw_en_o    (sw_en_o),
  .soa_trip_o (soa_trip_o)
);

// File: tb/test_opt_guard.sv
module test_opt_guard;
  localparam int CLK_PERIOD = 10;
  localparam int PWR_W = 16;
  localparam int TRIP  = 5000;
  localparam int DWELL = 4;
  localparam int COOL  = 10;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic en_i = 1'b0;
  logic tick_i = 1'b1;
  logic [PWR_W-1:0] pwr_mw_i = '0;
  logic sw_en_o, soa_trip_o;

  int n_checks = 0;
  int n_errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  opt_guard #(
    .PWR_W(PWR_W), .TRIP_MW(TRIP), .DWELL_TICKS(DWELL), .COOL_TICKS(COOL)
  ) i_opt_guard (
    .clk_i(clk), .rst_ni(rst_ni), .en_i(en_i), .tick_i(tick_i),
    .pwr_mw_i(pwr_mw_i), .sw_en_o(sw_en_o), .soa_trip_o(soa_trip_o)
  );

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic sw_exp, input logic tr_exp);
    n_checks++;
    if (sw_en_o !== sw_exp || soa_trip_o !== tr_exp) begin
      n_errors++;
      $display("FAIL %s: sw_en=%b trip=%b expected sw_en=%b trip=%b at %0t",
               req, sw_en_o, soa_trip_o, sw_exp, tr_exp, $time);
    end
  endtask

  task automatic to_idle();
    en_i = 1'b0; pwr_mw_i = '0; tick_i = 1'b1;
    step(1);
    chk("R9", 1'b0, 1'b0);
    en_i = 1'b1;
    step(1);
    chk("R2", 1'b1, 1'b0);
  endtask

  task automatic t_reset();
    step(3);
    chk("R1", 1'b0, 1'b0);
    rst_ni = 1'b1;
    step(2);
    chk("R1", 1'b0, 1'b0);
  endtask

  task automatic t_enable();
    en_i = 1'b1;
    step(1);
    chk("R2", 1'b1, 1'b0);
    step(20);
    chk("R2", 1'b1, 1'b0);
  endtask

  task automatic t_threshold();
    pwr_mw_i = PWR_W'(TRIP - 1);
    step(30);
    chk("R3", 1'b1, 1'b0);
    pwr_mw_i = PWR_W'(TRIP);
    step(DWELL);
    chk("R4", 1'b1, 1'b0);
    step(1);
    chk("R4", 1'b0, 1'b1);
    to_idle();
  endtask

  task automatic t_excursion();
    pwr_mw_i = 16'd6000;
    step(DWELL);
    pwr_mw_i = 16'd100;
    step(1);
    chk("R5", 1'b1, 1'b0);
    pwr_mw_i = 16'd6000;
    step(DWELL);
    chk("R5", 1'b1, 1'b0);
    step(1);
    chk("R5", 1'b0, 1'b1);
    to_idle();
  endtask

  task automatic t_tick();
    tick_i = 1'b0;
    pwr_mw_i = 16'd9000;
    step(40);
    chk("R6", 1'b1, 1'b0);
    // one tick in every three cycles
    for (int k = 0; k < DWELL; k++) begin
      tick_i = 1'b1; step(1);
      tick_i = 1'b0; step(2);
    end
    chk("R6", 1'b1, 1'b0);
    tick_i = 1'b1; step(1);
    chk("R6", 1'b0, 1'b1);
    tick_i = 1'b0;
    step(30);
    chk("R7", 1'b0, 1'b1);
    to_idle();
  endtask

  task automatic t_cool();
    pwr_mw_i = 16'd6000;
    step(DWELL + 1);
    chk("R7", 1'b0, 1'b1);
    pwr_mw_i = '0;
    for (int k = 1; k < COOL; k++) begin
      step(1);
      chk("R7", 1'b0, 1'b1);
      if (sw_en_o && soa_trip_o) begin
        n_errors++;
        $display("FAIL R10: both outputs high, expected at most one");
      end
    end
    step(1);
    chk("R7", 1'b1, 1'b0);
    step(20);
    chk("R8", 1'b1, 1'b0);
    pwr_mw_i = 16'd6000;
    step(DWELL + 1);
    chk("R8", 1'b0, 1'b1);
    step(COOL);
    chk("R8", 1'b1, 1'b0);
    step(DWELL);
    chk("R8", 1'b1, 1'b0);
    step(1);
    chk("R8", 1'b0, 1'b1);
  endtask

  task automatic t_drop_cool();
    step(3);
    chk("R9", 1'b0, 1'b1);
    en_i = 1'b0;
    step(1);
    chk("R9", 1'b0, 1'b0);
    en_i = 1'b1;
    step(1);
    chk("R9", 1'b1, 1'b0);
    step(DWELL);
    chk("R9", 1'b1, 1'b0);
    step(1);
    chk("R9", 1'b0, 1'b1);
    en_i = 1'b0;
    step(1);
    chk("R9", 1'b0, 1'b0);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  endtask

  initial begin
    t_reset();
    t_enable();
    t_threshold();
    t_excursion();
    t_tick();
    t_cool();
    t_drop_cool();
    finish_run();
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_checks++;
    n_errors++;
    $display("FAIL watchdog: run did not complete, expected completion");
    finish_run();
  end
endmodule